// File: doc/BRIEF.md
# Serial Command and Fault-Status Port

This block is the serial slave front end of a four-channel output driver controller. A host selects it by pulling chip select low and clocks a command word in on the serial input. In the same transfer it receives a fault status word on the serial output. The block samples the serial pins with its own system clock. It finds the serial-clock and chip-select edges from synchronized copies of those pins, so all of its state lives in one clock domain.

When chip select goes low, the block captures the fault status of the four channels and the sticky frame-error flag, and it turns on its serial output driver. Data moves through a single shift register. Received bits enter at the bottom as status bits leave at the top, so a frame longer than 16 bits passes the earlier received bits on to the output. This lets several devices be chained. When chip select goes high, the output driver turns off. If the frame length was valid, the low four bits of the register become the new channel enables. Otherwise the command is dropped and the error flag is set. An active-low global enable pin gates the four driver outputs directly, without affecting the serial logic.

Top module: `spi_drv_top`

## Requirements
- R1: After reset, all four driver enables are 0, the serial output enable is 0 and the frame-error flag is 0.
- R2: The serial output enable is 1 while chip select is low and 0 while it is high, following each chip-select edge by at most three clock cycles.
- R3: On the falling edge of chip select, the status word is loaded into the shift register and its bit 15 appears on the serial output before the first serial-clock rising edge. The status word has bit 15 = frame-error flag, bits 14..4 = 0, and bit n = 1 when channel n is faulted (0 when healthy).
- R4: The serial output advances by one bit on each serial-clock falling edge, most significant bit first, so the host reads the 16 status bits in order on successive rising edges.
- R5: Serial input is sampled on serial-clock rising edges, most significant bit first. On the rising edge of chip select after a 16-bit frame, command bits 3..0 become the enables of channels 3..0.
- R6: A frame of 24 or 32 bits is valid, and the last 16 bits received form the command. Bits clocked out after the first 16 are the bits received at the start of the frame.
- R7: A frame whose bit count is below 16 or not a multiple of 8 (0, 8 or 17 bits, for example) leaves the enables unchanged and sets the frame-error flag.
- R8: The frame-error flag stays set until the next chip-select falling edge, which reports it in status bit 15 and then clears it.
- R9: While the global enable pin is high, all four driver outputs are 0. The stored enables are kept and reappear as soon as the pin goes low.
- R10: Serial-clock and serial-input activity while chip select is high has no effect: the output stays disabled, the enables do not change and the bit count of the next frame is not advanced.
- R11: Command bits 15..4 are reserved. Nonzero values there do not affect the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial pins |
| rstN | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from the host, idle low |
| serIn | input | 1 | Serial command data |
| csN | input | 1 | Active-low chip select |
| outEnN | input | 1 | Active-low global driver enable |
| faultIn | input | 4 | Fault indication for each channel, 1 = faulted |
| serOut | output | 1 | Serial status data |
| serOutEn | output | 1 | Tri-state enable for serOut, 1 = driven |
| drvEn | output | 4 | Gated driver enables, one per channel |
| frameErr | output | 1 | Sticky frame-error flag |

## Verification
Each serial pin passes through a two-stage synchronizer and an edge detector, so any effect of a serial-clock or chip-select edge is registered on the third rising clock edge after the pin changes. The effect of the global enable pin is combinational and appears in the same cycle. The bench holds every serial pin level for four clock periods and samples outputs on falling clock edges only after that hold. Serial-output bits are read just before the bench raises the serial clock, and the driver gate is checked one falling edge after the enable pin moves.

// File: rtl/spi_drv_pkg.sv
package spi_drv_pkg;
  localparam int WORD_W = 16;
  localparam int CHAN_N = 4;

  typedef struct packed {
    logic load;     // chip-select fall: capture status, drive output
    logic drop;     // chip-select rise: stop driving output
    logic sample;   // serial-clock rise inside a frame
    logic shift;    // serial-clock fall inside a frame
    logic commit;   // valid frame ended
    logic reject;   // invalid frame ended
    logic serInBit; // synchronized serial input
  } strobe_t;
endpackage

// File: rtl/spi_drv_sync.sv
module spi_drv_sync #(
  parameter int WIDTH = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain[s] <= RESET_VAL;
        else if (s == 0) chain[s] <= din;
        else chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/spi_drv_ctrl.sv
module spi_drv_ctrl
  import spi_drv_pkg::*;
#(
  parameter int WORD = WORD_W,
  parameter int CNT_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    sclk,
  input  logic    serIn,
  input  logic    csN,
  output strobe_t strb
);
  localparam int BYTE_BITS = 8;
  localparam int BYTE_LSB = $clog2(BYTE_BITS);
  localparam logic [CNT_W-1:0] MIN_BITS = CNT_W'(WORD);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [2:0] pinSync;
  logic csSync, sclkSync, siSync;
  logic csPrev, sclkPrev;
  logic inFrame, csFall, csRise, frameOk;
  logic [CNT_W-1:0] bitCnt;

  spi_drv_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RESET_VAL(3'b100)) i_sync (
    .clk(clk), .rstN(rstN), .din({csN, sclk, serIn}), .dout(pinSync)
  );
  assign {csSync, sclkSync, siSync} = pinSync;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csPrev <= 1'b1;
      sclkPrev <= 1'b0;
    end else begin
      csPrev <= csSync;
      sclkPrev <= sclkSync;
    end
  end

  assign csFall = csPrev & ~csSync;
  assign csRise = ~csPrev & csSync;
  assign inFrame = ~csPrev & ~csSync;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) bitCnt <= '0;
    else if (csFall) bitCnt <= '0;
    else if (strb.sample && bitCnt != CNT_MAX) bitCnt <= bitCnt + 1'b1;
  end

  assign frameOk = (bitCnt >= MIN_BITS) && (bitCnt[BYTE_LSB-1:0] == '0);

  always_comb begin
    strb.load = csFall;
    strb.drop = csRise;
    strb.sample = inFrame & sclkSync & ~sclkPrev;
    strb.shift = inFrame & ~sclkSync & sclkPrev;
    strb.commit = csRise & frameOk;
    strb.reject = csRise & ~frameOk;
    strb.serInBit = siSync;
  end

  // R10
  idle_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    (csPrev && csSync) |=> $stable(bitCnt));

  // R2
  edge_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.drop |=> !strb.sample && !strb.shift);
endmodule

// File: rtl/spi_drv_dp.sv
module spi_drv_dp
  import spi_drv_pkg::*;
#(
  parameter int WORD = WORD_W,
  parameter int CHANS = CHAN_N
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strb,
  input  logic [CHANS-1:0] faultIn,
  output logic             serOut,
  output logic             serOutEn,
  output logic [CHANS-1:0] enReg,
  output logic             errFlag
);
  localparam int PAD_W = WORD - 1 - CHANS;

  logic [WORD-1:0] shiftReg;
  logic [WORD-1:0] statusWord;
  logic siLatch;

  assign statusWord = {errFlag, {PAD_W{1'b0}}, faultIn};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      siLatch <= 1'b0;
    end else begin
      if (strb.sample) siLatch <= strb.serInBit;
      if (strb.load) shiftReg <= statusWord;
      else if (strb.shift) shiftReg <= {shiftReg[WORD-2:0], siLatch};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) serOutEn <= 1'b0;
    else if (strb.load) serOutEn <= 1'b1;
    else if (strb.drop) serOutEn <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) enReg <= '0;
    else if (strb.commit) enReg <= shiftReg[CHANS-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) errFlag <= 1'b0;
    else if (strb.reject) errFlag <= 1'b1;
    else if (strb.load) errFlag <= 1'b0;
  end

  assign serOut = shiftReg[WORD-1];

  // R7
  hold_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.commit |=> $stable(enReg));

  // R5
  commit_value_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit |=> enReg == $past(shiftReg[CHANS-1:0]));

  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.reject |=> errFlag);

  // R3
  status_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> serOutEn && serOut == $past(errFlag));
endmodule

// File: rtl/spi_drv_top.sv
module spi_drv_top
  import spi_drv_pkg::*;
#(
  parameter int WORD = WORD_W,
  parameter int CHANS = CHAN_N,
  parameter int CNT_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sclk,
  input  logic             serIn,
  input  logic             csN,
  input  logic             outEnN,
  input  logic [CHANS-1:0] faultIn,
  output logic             serOut,
  output logic             serOutEn,
  output logic [CHANS-1:0] drvEn,
  output logic             frameErr
);
  strobe_t strb;
  logic [CHANS-1:0] enReg;

  spi_drv_ctrl #(.WORD(WORD), .CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) i_ctrl (
    .clk(clk), .rstN(rstN), .sclk(sclk), .serIn(serIn), .csN(csN), .strb(strb)
  );

  spi_drv_dp #(.WORD(WORD), .CHANS(CHANS)) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .faultIn(faultIn),
    .serOut(serOut), .serOutEn(serOutEn), .enReg(enReg), .errFlag(frameErr)
  );

  assign drvEn = outEnN ? '0 : enReg;
endmodule

// File: tb/test_spi_drv_top.sv
module test_spi_drv_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclk = 1'b0;
  logic serIn = 1'b0;
  logic csN = 1'b1;
  logic outEnN = 1'b0;
  logic [3:0] faultIn = 4'b0000;
  logic serOut, serOutEn, frameErr;
  logic [3:0] drvEn;
  int nChecks = 0;
  int nFails = 0;
  bit finished = 0;
  localparam int HOLD = 4;

  always #10 clk = ~clk;

  spi_drv_top i_spi_drv_top (
    .clk(clk), .rstN(rstN), .sclk(sclk), .serIn(serIn), .csN(csN),
    .outEnN(outEnN), .faultIn(faultIn), .serOut(serOut),
    .serOutEn(serOutEn), .drvEn(drvEn), .frameErr(frameErr)
  );

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic frame(input int nBits, input logic [63:0] data,
                       output logic [63:0] got);
    got = '0;
    csN = 1'b0;
    waitN(HOLD);
    check("R2", "output enable in frame", 64'(serOutEn), 64'd1);
    for (int i = 0; i < nBits; i++) begin
      got = {got[62:0], serOut};
      serIn = data[nBits-1-i];
      waitN(HOLD);
      sclk = 1'b1;
      waitN(HOLD);
      sclk = 1'b0;
      waitN(HOLD);
    end
    csN = 1'b1;
    waitN(HOLD);
    check("R2", "output enable after frame", 64'(serOutEn), 64'd0);
  endtask

  task automatic testReset();
    check("R1", "drvEn", 64'(drvEn), 64'd0);
    check("R1", "serOutEn", 64'(serOutEn), 64'd0);
    check("R1", "frameErr", 64'(frameErr), 64'd0);
  endtask

  task automatic testBasic();
    logic [63:0] got;
    faultIn = 4'b1010;
    frame(16, 64'h0005, got);
    check("R3", "status word bits", got, 64'h000A);
    check("R4", "status msb-first order", 64'(got[3:0]), 64'hA);
    check("R5", "enables after 16-bit frame", 64'(drvEn), 64'h5);
  endtask

  task automatic testLong();
    logic [63:0] got;
    faultIn = 4'b0000;
    frame(24, 64'hABC00C, got);
    check("R6", "24-bit chained output", got, 64'h0000AB);
    check("R11", "reserved bits ignored", 64'(drvEn), 64'hC);
    frame(32, 64'h1234_0009, got);
    check("R6", "32-bit chained output", got, 64'h0000_1234);
    check("R6", "32-bit command", 64'(drvEn), 64'h9);
  endtask

  task automatic testErrors();
    logic [63:0] got;
    frame(8, 64'hFF, got);
    check("R7", "8-bit enables held", 64'(drvEn), 64'h9);
    check("R7", "8-bit error flag", 64'(frameErr), 64'd1);
    frame(17, 64'h1FFFF, got);
    check("R7", "17-bit enables held", 64'(drvEn), 64'h9);
    frame(0, 64'h0, got);
    check("R7", "empty frame error flag", 64'(frameErr), 64'd1);
    faultIn = 4'b0001;
    frame(16, 64'h0003, got);
    check("R8", "flag in status", got, 64'h8001);
    check("R8", "flag cleared", 64'(frameErr), 64'd0);
    check("R5", "enables after recovery", 64'(drvEn), 64'h3);
  endtask

  task automatic testOutEn();
    outEnN = 1'b1;
    waitN(1);
    check("R9", "gated off", 64'(drvEn), 64'h0);
    outEnN = 1'b0;
    waitN(1);
    check("R9", "restored", 64'(drvEn), 64'h3);
  endtask

  task automatic testIdle();
    logic [63:0] got;
    serIn = 1'b1;
    for (int i = 0; i < 10; i++) begin
      sclk = 1'b1;
      waitN(HOLD);
      check("R10", "output disabled while idle", 64'(serOutEn), 64'd0);
      sclk = 1'b0;
      waitN(HOLD);
    end
    check("R10", "enables unchanged while idle", 64'(drvEn), 64'h3);
    frame(16, 64'hF006, got);
    check("R10", "next frame valid", 64'(frameErr), 64'd0);
    check("R11", "enables with reserved set", 64'(drvEn), 64'h6);
  endtask

  initial begin
    waitN(3);
    testReset();
    rstN = 1'b1;
    waitN(3);
    testReset();
    testBasic();
    testLong();
    testErrors();
    testOutEn();
    testIdle();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule